// File: doc/BRIEF.md
# Two-Channel PWM Register Front End

This block is the register front end of a two-channel pulse-width modulator. A simple 32-bit bus reaches it through an address, a write strobe, write data and registered read data. It holds two shared control registers and, for each channel, a split 16-bit frequency control word, an on-time value and a period value. The register contents drive the control lines of the frequency-generator and waveform-generator cores, which are instantiated elsewhere.

The block also models each channel's pad. It takes the waveform produced by the PWM core and turns it into a registered output-enable and level pair. The pad logic applies three settings in this order: force-high first, then the open-drain or push-pull choice, then the active-low output enable that can release the line completely. Software turns a channel on by setting its start and open-drain bits and clearing its output-enable-bar bit, and turns it off by doing the reverse.

Top module: `pwmfe_top`

## Requirements
- R1: After synchronous reset, the main control register at 0x00 reads 0x22, because the active-low output enable of each channel is set. Every other register reads 0, and both pads have pad_oe_o = 0 and pad_level_o = 0.
- R2: The main control register at 0x00 holds a 4-bit field for channel c at bits [4c+3:4c]. Bit 4c is start, bit 4c+1 is the active-low output enable, bit 4c+2 is force-high and bit 4c+3 is open-drain. The matching outputs follow the written value from the cycle after the write.
- R3: Register 0x04 holds channel c's output-select bit at bit 4c, which drives out_sel_o[c].
- R4: Channel c's control word has its high byte at 0x08+8c and its low byte at 0x0C+8c. Each byte is 8 bits wide, and cword_o[16c+15:16c] = {high, low}.
- R5: Channel c's on-time is at 0x18+8c and its period is at 0x1C+8c. Each is 8 bits wide and appears on on_time_o[8c+7:8c] and period_o[8c+7:8c].
- R6: Register bits that are not defined read as zero, and writes to them are dropped.
- R7: Every address outside the map, including addresses that are not word-aligned, reads as zero. Writes to such addresses change no register.
- R8: bus_rdata holds the contents of the register addressed at the previous clock edge, one cycle of latency, and back-to-back reads return one result per cycle.
- R9: While a channel's active-low output enable is 1, its pad has pad_oe_o = 0 and pad_level_o = 0, whatever the waveform and the other settings.
- R10: In open-drain mode with the output enabled, the pad drives low (pad_oe_o = 1, pad_level_o = 0) only when the effective level is 0. When the effective level is 1 it releases the line (pad_oe_o = 0).
- R11: In push-pull mode with the output enabled, pad_oe_o = 1 and pad_level_o equals the effective level.
- R12: Force-high makes the effective level 1 whatever the waveform input, before the open-drain choice is applied.
- R13: The pad outputs are registered. A change on wave_i appears on the pad pins after the next rising clock edge and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| wave_i | input | 2 | Waveform from each channel's PWM core |
| start_o | output | 2 | Start control per channel |
| out_sel_o | output | 2 | Output-select control per channel |
| force_hi_o | output | 2 | Force-high control per channel |
| oe_n_o | output | 2 | Active-low output enable per channel |
| open_drain_o | output | 2 | Open-drain mode per channel |
| cword_o | output | 32 | 16-bit control word per channel |
| on_time_o | output | 16 | 8-bit on-time per channel |
| period_o | output | 16 | 8-bit period per channel |
| pad_oe_o | output | 2 | Pad driver enable per channel |
| pad_level_o | output | 2 | Pad driven level per channel |

## Verification
A wrong decode or a wrong field position shows up in two places: on the bus one cycle after the read address is presented, and on the control output pins from the cycle after the write. An unmapped write that wrongly lands in a register stays hidden until that register is read back, so the bench rereads every register after writing to holes in the map. Wrong pad gating shows up two clock edges after the control write: one edge to update the register and one edge for the registered pad stage. The bench therefore samples the pads only after both edges, and it also checks that a waveform change does not reach the pads before the next edge.

// File: rtl/pwmfe_pkg.sv
package pwmfe_pkg;
  localparam int unsigned FLD_W     = 4;
  localparam int unsigned CH_STRIDE = 8;
  localparam int unsigned B_START   = 0;
  localparam int unsigned B_OEN     = 1;
  localparam int unsigned B_FORCE   = 2;
  localparam int unsigned B_OD      = 3;

  typedef struct packed {
    logic start;
    logic oe_n;
    logic force_hi;
    logic open_drain;
    logic out_sel;
  } chan_ctl_t;
endpackage

// File: rtl/pwmfe_decode.sv
module pwmfe_decode #(
  parameter int unsigned NCH = 2,
  parameter int unsigned AW  = 8
) (
  input  logic [AW-1:0]  bus_addr,
  output logic           sel_ctrl,
  output logic           sel_ctrl2,
  output logic [NCH-1:0] sel_cw_hi,
  output logic [NCH-1:0] sel_cw_lo,
  output logic [NCH-1:0] sel_on,
  output logic [NCH-1:0] sel_per,
  output logic           hit
);
  import pwmfe_pkg::*;

  localparam int unsigned CW_HI_BASE = 8;
  localparam int unsigned CW_LO_BASE = CW_HI_BASE + 4;
  localparam int unsigned ON_BASE    = CW_HI_BASE + CH_STRIDE * NCH;
  localparam int unsigned PER_BASE   = ON_BASE + 4;

  always_comb begin
    sel_ctrl  = (bus_addr == AW'(0));
    sel_ctrl2 = (bus_addr == AW'(4));
    for (int c = 0; c < NCH; c++) begin
      sel_cw_hi[c] = (bus_addr == AW'(CW_HI_BASE + CH_STRIDE * c));
      sel_cw_lo[c] = (bus_addr == AW'(CW_LO_BASE + CH_STRIDE * c));
      sel_on[c]    = (bus_addr == AW'(ON_BASE + CH_STRIDE * c));
      sel_per[c]   = (bus_addr == AW'(PER_BASE + CH_STRIDE * c));
    end
    hit = sel_ctrl | sel_ctrl2 | (|sel_cw_hi) | (|sel_cw_lo) | (|sel_on) | (|sel_per);
  end
endmodule

// File: rtl/pwmfe_regs.sv
module pwmfe_regs #(
  parameter int unsigned NCH = 2,
  parameter int unsigned DW  = 32,
  parameter int unsigned VW  = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          bus_we,
  input  logic [DW-1:0]                 bus_wdata,
  input  logic                          sel_ctrl,
  input  logic                          sel_ctrl2,
  input  logic [NCH-1:0]                sel_cw_hi,
  input  logic [NCH-1:0]                sel_cw_lo,
  input  logic [NCH-1:0]                sel_on,
  input  logic [NCH-1:0]                sel_per,
  input  logic                          hit,
  output logic [DW-1:0]                 bus_rdata,
  output pwmfe_pkg::chan_ctl_t [NCH-1:0] ctl_o,
  output logic [NCH-1:0][2*VW-1:0]      cword_o,
  output logic [NCH-1:0][VW-1:0]        on_o,
  output logic [NCH-1:0][VW-1:0]        per_o
);
  import pwmfe_pkg::*;

  localparam int unsigned CW = FLD_W * NCH;

  function automatic logic [CW-1:0] ctrl_reset_f();
    logic [CW-1:0] v;
    v = '0;
    for (int c = 0; c < NCH; c++) v[FLD_W*c + B_OEN] = 1'b1;
    return v;
  endfunction

  localparam logic [CW-1:0] CTRL_RST = ctrl_reset_f();

  logic [CW-1:0]          ctrl_q;
  logic [NCH-1:0]         osel_q;
  logic [NCH-1:0][VW-1:0] cw_hi_q, cw_lo_q, on_q, per_q;
  logic [DW-1:0]          rd_next, rdata_q;
  logic                   unused_wdata;

  assign unused_wdata = ^bus_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= CTRL_RST;
      osel_q  <= '0;
      cw_hi_q <= '0;
      cw_lo_q <= '0;
      on_q    <= '0;
      per_q   <= '0;
    end else if (bus_we) begin
      if (sel_ctrl) ctrl_q <= bus_wdata[CW-1:0];
      for (int c = 0; c < NCH; c++) begin
        if (sel_ctrl2)    osel_q[c]  <= bus_wdata[FLD_W*c];
        if (sel_cw_hi[c]) cw_hi_q[c] <= bus_wdata[VW-1:0];
        if (sel_cw_lo[c]) cw_lo_q[c] <= bus_wdata[VW-1:0];
        if (sel_on[c])    on_q[c]    <= bus_wdata[VW-1:0];
        if (sel_per[c])   per_q[c]   <= bus_wdata[VW-1:0];
      end
    end
  end

  always_comb begin
    rd_next = '0;
    if (sel_ctrl) rd_next[CW-1:0] = ctrl_q;
    for (int c = 0; c < NCH; c++) begin
      if (sel_ctrl2)    rd_next[FLD_W*c] = osel_q[c];
      if (sel_cw_hi[c]) rd_next[VW-1:0]  = cw_hi_q[c];
      if (sel_cw_lo[c]) rd_next[VW-1:0]  = cw_lo_q[c];
      if (sel_on[c])    rd_next[VW-1:0]  = on_q[c];
      if (sel_per[c])   rd_next[VW-1:0]  = per_q[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_next;
  end

  assign bus_rdata = rdata_q;

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_out
      assign ctl_o[c].start      = ctrl_q[FLD_W*c + B_START];
      assign ctl_o[c].oe_n       = ctrl_q[FLD_W*c + B_OEN];
      assign ctl_o[c].force_hi   = ctrl_q[FLD_W*c + B_FORCE];
      assign ctl_o[c].open_drain = ctrl_q[FLD_W*c + B_OD];
      assign ctl_o[c].out_sel    = osel_q[c];
      assign cword_o[c]          = {cw_hi_q[c], cw_lo_q[c]};
      assign on_o[c]             = on_q[c];
      assign per_o[c]            = per_q[c];
    end
  endgenerate

  // R1: reset leaves outputs disabled and read data cleared
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (ctrl_q == CTRL_RST && rdata_q == '0 && osel_q == '0));

  // R7: a write outside the map leaves every register untouched
  p_hole_write_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_we && !hit) |=> ($stable(ctrl_q) && $stable(osel_q) && $stable(cw_hi_q)
                          && $stable(cw_lo_q) && $stable(on_q) && $stable(per_q)));

  // R7: a read outside the map returns zero one cycle later
  p_hole_read_r7: assert property (@(posedge clk) disable iff (rst)
    !hit |=> (bus_rdata == '0));

  // R6: second control register reads only its select bits
  p_ctrl2_bits_r6: assert property (@(posedge clk) disable iff (rst)
    (sel_ctrl2 && !sel_ctrl) |=> ($countones(bus_rdata) <= NCH));
endmodule

// File: rtl/pwmfe_pad.sv
module pwmfe_pad (
  input  logic                 clk,
  input  logic                 rst,
  input  pwmfe_pkg::chan_ctl_t ctl,
  input  logic                 wave,
  output logic                 pad_oe,
  output logic                 pad_level
);
  logic eff, oe_d, lvl_d, oe_q, lvl_q;
  logic unused_ctl;

  assign unused_ctl = ctl.start ^ ctl.out_sel;
  assign eff = ctl.force_hi | wave;

  always_comb begin
    if (ctl.oe_n) begin
      oe_d  = 1'b0;
      lvl_d = 1'b0;
    end else if (ctl.open_drain) begin
      oe_d  = ~eff;
      lvl_d = 1'b0;
    end else begin
      oe_d  = 1'b1;
      lvl_d = eff;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q  <= 1'b0;
      lvl_q <= 1'b0;
    end else begin
      oe_q  <= oe_d;
      lvl_q <= lvl_d;
    end
  end

  assign pad_oe    = oe_q;
  assign pad_level = lvl_q;

  // R9: disabled output never drives the line
  p_tristate_r9: assert property (@(posedge clk) disable iff (rst)
    ctl.oe_n |=> (!pad_oe && !pad_level));

  // R10: open-drain never drives a high level
  p_od_low_only_r10: assert property (@(posedge clk) disable iff (rst)
    (!ctl.oe_n && ctl.open_drain) |=> !pad_level);

  // R11: push-pull always drives, following the waveform
  p_pp_drive_r11: assert property (@(posedge clk) disable iff (rst)
    (!ctl.oe_n && !ctl.open_drain && !ctl.force_hi) |=> (pad_oe && pad_level == $past(wave)));

  // R12: forced level is high in push-pull, released in open-drain
  p_force_r12: assert property (@(posedge clk) disable iff (rst)
    (!ctl.oe_n && ctl.force_hi) |=> (ctl.open_drain ? 1'b1 : 1'b1) && ($past(ctl.open_drain) ? !pad_oe : pad_level));
endmodule

// File: rtl/pwmfe_top.sv
module pwmfe_top #(
  parameter int unsigned NCH = 2,
  parameter int unsigned AW  = 8,
  parameter int unsigned DW  = 32,
  parameter int unsigned VW  = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [AW-1:0]       bus_addr,
  input  logic                bus_we,
  input  logic [DW-1:0]       bus_wdata,
  output logic [DW-1:0]       bus_rdata,
  input  logic [NCH-1:0]      wave_i,
  output logic [NCH-1:0]      start_o,
  output logic [NCH-1:0]      out_sel_o,
  output logic [NCH-1:0]      force_hi_o,
  output logic [NCH-1:0]      oe_n_o,
  output logic [NCH-1:0]      open_drain_o,
  output logic [NCH*2*VW-1:0] cword_o,
  output logic [NCH*VW-1:0]   on_time_o,
  output logic [NCH*VW-1:0]   period_o,
  output logic [NCH-1:0]      pad_oe_o,
  output logic [NCH-1:0]      pad_level_o
);
  logic                           sel_ctrl, sel_ctrl2, hit;
  logic [NCH-1:0]                 sel_cw_hi, sel_cw_lo, sel_on, sel_per;
  pwmfe_pkg::chan_ctl_t [NCH-1:0] ctl;
  logic [NCH-1:0][2*VW-1:0]       cword;
  logic [NCH-1:0][VW-1:0]         on_v, per_v;

  pwmfe_decode #(.NCH(NCH), .AW(AW)) u_dec (
    .bus_addr (bus_addr),
    .sel_ctrl (sel_ctrl),
    .sel_ctrl2(sel_ctrl2),
    .sel_cw_hi(sel_cw_hi),
    .sel_cw_lo(sel_cw_lo),
    .sel_on   (sel_on),
    .sel_per  (sel_per),
    .hit      (hit)
  );

  pwmfe_regs #(.NCH(NCH), .DW(DW), .VW(VW)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .bus_we   (bus_we),
    .bus_wdata(bus_wdata),
    .sel_ctrl (sel_ctrl),
    .sel_ctrl2(sel_ctrl2),
    .sel_cw_hi(sel_cw_hi),
    .sel_cw_lo(sel_cw_lo),
    .sel_on   (sel_on),
    .sel_per  (sel_per),
    .hit      (hit),
    .bus_rdata(bus_rdata),
    .ctl_o    (ctl),
    .cword_o  (cword),
    .on_o     (on_v),
    .per_o    (per_v)
  );

  assign cword_o   = cword;
  assign on_time_o = on_v;
  assign period_o  = per_v;

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      assign start_o[c]      = ctl[c].start;
      assign out_sel_o[c]    = ctl[c].out_sel;
      assign force_hi_o[c]   = ctl[c].force_hi;
      assign oe_n_o[c]       = ctl[c].oe_n;
      assign open_drain_o[c] = ctl[c].open_drain;

      pwmfe_pad u_pad (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl[c]),
        .wave     (wave_i[c]),
        .pad_oe   (pad_oe_o[c]),
        .pad_level(pad_level_o[c])
      );
    end
  endgenerate
endmodule

// File: tb/sim_pwmfe_top.sv
`timescale 1ns/1ps
module sim_pwmfe_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  wave = '0;
  logic [1:0]  start, osel, force_hi, oe_n, od, pad_oe, pad_lvl;
  logic [31:0] cword;
  logic [15:0] on_t, per;

  int n_vec = 0;
  int n_bad = 0;
  logic rd_flag = 1'b0;
  logic [31:0] exp_q[$];
  string       req_q[$];

  always #2.5 clk = ~clk;

  pwmfe_top u0 (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
    .bus_rdata(rdata), .wave_i(wave), .start_o(start), .out_sel_o(osel),
    .force_hi_o(force_hi), .oe_n_o(oe_n), .open_drain_o(od), .cword_o(cword),
    .on_time_o(on_t), .period_o(per), .pad_oe_o(pad_oe), .pad_level_o(pad_lvl)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; we = 1'b1; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  // driver: push expected read data into the scoreboard
  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    addr = a;
    exp_q.push_back(exp);
    req_q.push_back(req);
    rd_flag = 1'b1;
    @(negedge clk);
    rd_flag = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  // monitor: read data is due one edge after the address (R8)
  always @(posedge clk) begin
    if (rd_flag) begin
      #1;
      if (exp_q.size() == 0) begin
        n_vec++; n_bad++;
        $display("FAIL R8 actual=unexpected-read expected=queued-item");
      end else begin
        logic [31:0] e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        chk(rdata, e, r);
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk({30'd0, oe_n}, 32'h3, "R1 oe_n");
    chk({28'd0, pad_oe, pad_lvl}, 32'h0, "R1 pads");
    chk({30'd0, start}, 32'h0, "R1 start");
    rd(8'h00, 32'h22, "R1 ctrl");
    rd(8'h08, 32'h0, "R1 cword hi");

    // R2 enable-style field write
    wr(8'h00, 32'h0000_0019);
    chk({24'd0, start, oe_n, od, force_hi}, {24'd0, 2'b11, 2'b00, 2'b01, 2'b00}, "R2 fields");
    rd(8'h00, 32'h19, "R2 ctrl readback");

    // R6 undefined bits
    wr(8'h00, 32'hFFFF_FF00);
    rd(8'h00, 32'h0, "R6 ctrl upper");
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, 32'h11, "R6 ctrl2");
    // R3 output select position
    chk({30'd0, osel}, 32'h3, "R3 osel both");
    wr(8'h04, 32'h10);
    rd(8'h04, 32'h10, "R3 ctrl2");
    chk({30'd0, osel}, 32'h2, "R3 osel ch1");

    // R4 control words
    wr(8'h08, 32'h1AB);
    wr(8'h0C, 32'hCD);
    wr(8'h10, 32'h12);
    wr(8'h14, 32'h34);
    chk(cword, 32'h1234_ABCD, "R4 cword");
    rd(8'h08, 32'hAB, "R4 hi ch0");
    rd(8'h14, 32'h34, "R4 lo ch1");

    // R5 on-time and period
    wr(8'h18, 32'h80);
    wr(8'h1C, 32'hFE);
    wr(8'h20, 32'h01);
    wr(8'h24, 32'hFF);
    chk({16'd0, on_t}, 32'h0180, "R5 on");
    chk({16'd0, per}, 32'hFFFE, "R5 period");
    rd(8'h20, 32'h01, "R5 on ch1");

    // R7 holes in the map
    wr(8'h28, 32'hFFFF_FFFF);
    wr(8'h02, 32'hFFFF_FFFF);
    wr(8'hFC, 32'hFFFF_FFFF);
    rd(8'h28, 32'h0, "R7 read 0x28");
    rd(8'h02, 32'h0, "R7 read 0x02");
    rd(8'h00, 32'h0, "R7 ctrl kept");
    rd(8'h04, 32'h10, "R7 ctrl2 kept");
    rd(8'h24, 32'hFF, "R7 period kept");
    chk(cword, 32'h1234_ABCD, "R7 cword kept");

    // R8 back-to-back reads, one result per cycle
    @(negedge clk);
    addr = 8'h0C; exp_q.push_back(32'hCD); req_q.push_back("R8 b2b first"); rd_flag = 1'b1;
    @(negedge clk);
    addr = 8'h18; exp_q.push_back(32'h80); req_q.push_back("R8 b2b second");
    @(negedge clk);
    rd_flag = 1'b0;

    // R11 push-pull
    wave = 2'b01;
    settle();
    chk({30'd0, pad_oe}, 32'h3, "R11 oe");
    chk({30'd0, pad_lvl}, 32'h1, "R11 level 01");
    wave = 2'b10;
    settle();
    chk({30'd0, pad_lvl}, 32'h2, "R11 level 10");

    // R10 open-drain
    wr(8'h00, 32'h88);
    wave = 2'b01;
    settle();
    chk({30'd0, pad_oe}, 32'h2, "R10 oe");
    chk({30'd0, pad_lvl}, 32'h0, "R10 level");

    // R12 force-high: ch0 push-pull, ch1 open-drain
    wr(8'h00, 32'hC4);
    wave = 2'b00;
    settle();
    chk({30'd0, pad_oe}, 32'h1, "R12 oe");
    chk({30'd0, pad_lvl}, 32'h1, "R12 level");

    // R9 output disabled
    wr(8'h00, 32'h2A);
    wave = 2'b11;
    settle();
    chk({28'd0, pad_oe, pad_lvl}, 32'h0, "R9 od+oe_n");
    wr(8'h00, 32'h66);
    settle();
    chk({28'd0, pad_oe, pad_lvl}, 32'h0, "R9 force+oe_n");

    // R13 pad register stage
    wr(8'h00, 32'h00);
    wave = 2'b00;
    settle();
    chk({30'd0, pad_lvl}, 32'h0, "R13 before");
    wave = 2'b11;
    #0.5;
    chk({30'd0, pad_lvl}, 32'h0, "R13 not before edge");
    @(negedge clk);
    chk({30'd0, pad_lvl}, 32'h3, "R13 after edge");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_vec++; n_bad++;
      $display("FAIL R8 actual=%0d expected=0 pending reads", exp_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule